// File: doc/BRIEF.md
# Single-Channel DMA Controller with Bus Grant

The block moves a block of words between memory and one peripheral data port so that the processor does not copy each word itself. Software loads a memory address, a word count and a control word. The control word has a run bit, a direction bit and a mode bit. The register port is a plain I/O-style interface: a chip-select, a two-bit register index, and read and write strobes. Register access works only while the bus grant input is low.

Setting the run bit with a nonzero count makes the controller raise its bus request. Whenever the grant is high and the request is raised, one word moves in that cycle. The controller drives the memory address and a read or write strobe. After each word the address steps up by one and the count steps down by one. In burst mode the request stays raised until the last word has moved. In single-word mode the request drops after every word and is raised again once the grant has gone away. A one-cycle completion pulse marks the end of a block.

Top module: `dma_burst_ctl`

## Requirements
- R1: After reset the bus request, the memory strobes, the completion pulse and the peripheral valid flag are low, and the address, count and control registers read back as zero.
- R2: While grant is low, a write with chip-select high stores write data in the register chosen by the index: 0 is the address, 1 is the count, 2 is control. In the control word, bit 0 is run, bit 1 is direction (1 means memory write) and bit 2 is mode (1 means single-word). Reads return the stored values combinationally, with control read as {mode, direction, run}. Index 3 reads zero.
- R3: While grant is high, register writes are ignored and read data is zero.
- R4: Setting run with a nonzero count raises the bus request in the next cycle. No memory strobe is issued while grant is low.
- R5: A word moves in each cycle where request and grant are both high. The memory address output equals the address register while grant is high and is zero otherwise. After each word the address increments by one and the count decrements by one.
- R6: With direction 0, the cycle pulses the memory read strobe. The read word then appears on the peripheral output one cycle later, with a one-cycle valid flag. With direction 1, the cycle pulses the memory write strobe with the peripheral input word as write data, and pulses the peripheral take strobe.
- R7: In burst mode the request stays high without a break from the start until the last word. It drops in the cycle after the last word.
- R8: In single-word mode the request drops after each word. It stays low until grant has been seen low, then rises again while words remain.
- R9: In the cycle after the last word, the completion pulse is high for exactly one cycle, the run bit reads 0 and the count reads 0.
- R10: Setting run with a count of zero produces the completion pulse in the next cycle and never raises the request.
- R11: While run is set, register writes are ignored, except that writing control with bit 0 clear aborts the transfer. An abort drops the request with no completion pulse and leaves address and count unchanged.
- R12: The memory read and write strobes are never high together, and neither is high unless both request and grant are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Chip-select for the register port |
| reg_sel | input | 2 | Register index |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| per_din | input | DW | Peripheral word going to memory |
| per_take | output | 1 | Peripheral word consumed |
| per_dout | output | DW | Word read from memory for the peripheral |
| per_valid | output | 1 | per_dout valid for one cycle |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Several transfer patterns are used:
- A four-word burst read with a grant that follows the request one cycle late. It separates continuous request holding from per-word release, and checks that each word read appears at the peripheral output.
- A three-word single-word write. It shows that the request is re-raised once per word, and that the memory write lands on exactly the programmed locations and nowhere past them.
- A zero-count start and an abort under a held-off grant. These separate immediate completion from an aborted run, which must produce no pulse.
- Register writes tried with the grant forced high. These show that access gating blocks them.

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic [1:0]    reg_sel,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] per_din,
  output logic          per_take,
  output logic [DW-1:0] per_dout,
  output logic          per_valid,
  output logic          done_irq
);
  localparam logic [1:0] IDX_ADDR = 2'd0;
  localparam logic [1:0] IDX_CNT  = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, dir_q, single_q, gap_q, done_q, pv_q;
  logic [DW-1:0] pd_q;

  wire cpu_wr_ok = cpu_sel & cpu_wr & ~bus_gnt;
  wire xfer      = bus_req & bus_gnt;
  wire last_word = (cnt_q == CW'(1));

  assign bus_req   = run_q & ~gap_q;
  assign mem_addr  = bus_gnt ? addr_q : '0;
  assign mem_rd    = xfer & ~dir_q;
  assign mem_wr    = xfer & dir_q;
  assign mem_wdata = per_din;
  assign per_take  = mem_wr;
  assign per_dout  = pd_q;
  assign per_valid = pv_q;
  assign done_irq  = done_q;

  always_comb begin
    cpu_rdata = '0;
    if (cpu_sel && cpu_rd && !bus_gnt) begin
      case (reg_sel)
        IDX_ADDR: cpu_rdata = DW'(addr_q);
        IDX_CNT:  cpu_rdata = DW'(cnt_q);
        IDX_CTRL: cpu_rdata = DW'({single_q, dir_q, run_q});
        default:  cpu_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      dir_q    <= 1'b0;
      single_q <= 1'b0;
      gap_q    <= 1'b0;
      done_q   <= 1'b0;
      pv_q     <= 1'b0;
      pd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      pv_q   <= 1'b0;
      if (xfer) begin
        addr_q <= addr_q + AW'(1);
        cnt_q  <= cnt_q - CW'(1);
        if (!dir_q) begin
          pd_q <= mem_rdata;
          pv_q <= 1'b1;
        end
        if (last_word) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          gap_q  <= 1'b0;
        end else if (single_q) begin
          gap_q <= 1'b1;
        end
      end else if (gap_q && !bus_gnt) begin
        gap_q <= 1'b0;
      end
      if (cpu_wr_ok) begin
        if (run_q) begin
          if (reg_sel == IDX_CTRL && !cpu_wdata[0]) begin
            run_q <= 1'b0;
            gap_q <= 1'b0;
          end
        end else begin
          case (reg_sel)
            IDX_ADDR: addr_q <= AW'(cpu_wdata);
            IDX_CNT:  cnt_q  <= CW'(cpu_wdata);
            IDX_CTRL: begin
              dir_q    <= cpu_wdata[1];
              single_q <= cpu_wdata[2];
              if (cpu_wdata[0]) begin
                if (cnt_q == '0) done_q <= 1'b1;
                else             run_q  <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma_burst_ctl_chk.sv
module dma_burst_ctl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          done_irq,
  input logic          single_q,
  input logic [AW-1:0] addr_q
);
  // R12
  strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_gnt));
  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R9
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !bus_req);
  // R8
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && single_q) |=> !bus_req);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> (addr_q == $past(addr_q) + AW'(1)));
endmodule

bind dma_burst_ctl dma_burst_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .done_irq(done_irq),
  .single_q(single_q), .addr_q(addr_q)
);

// File: tb/dma_burst_ctl_test.sv
`timescale 1ns/1ps
module dma_burst_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_sel = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic        bus_req, mem_rd, mem_wr, per_take, per_valid, done_irq;
  logic        bus_gnt = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, per_din, per_dout;

  always #5 clk = ~clk;

  dma_burst_ctl uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .reg_sel(reg_sel),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_din(per_din),
    .per_take(per_take), .per_dout(per_dout), .per_valid(per_valid), .done_irq(done_irq)
  );

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];
  assign per_din   = {8'hC5, mem_addr[7:0]};
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // grant follows the request one cycle late when arb_en is set
  bit arb_en = 1'b0;
  logic req_s = 1'b0;
  always @(posedge clk) begin
    #1;
    if (arb_en) bus_gnt = req_s;
  end

  // behavioural reference state
  int ma, mc, mpd;
  bit mrun, mdir, msingle, mgap, mdone, mpv, r_req, r_x;
  always @(posedge clk) begin
    if (!rst_n) begin
      ma = 0; mc = 0; mpd = 0;
      mrun = 0; mdir = 0; msingle = 0; mgap = 0; mdone = 0; mpv = 0;
    end else begin
      r_req = mrun && !mgap;
      r_x = r_req && bus_gnt;
      mdone = 0; mpv = 0;
      if (r_x) begin
        if (!mdir) begin mpd = mem[ma & 255]; mpv = 1; end
        ma = (ma + 1) & 16'hFFFF;
        mc = mc - 1;
        if (mc == 0) begin mrun = 0; mdone = 1; mgap = 0; end
        else if (msingle) mgap = 1;
      end else if (mgap && !bus_gnt) mgap = 0;
      if (cpu_sel && cpu_wr && !bus_gnt) begin
        if (mrun) begin
          if (reg_sel == 2 && !cpu_wdata[0]) begin mrun = 0; mgap = 0; end
        end else begin
          case (reg_sel)
            2'd0: ma = cpu_wdata;
            2'd1: mc = cpu_wdata;
            2'd2: begin
              mdir = cpu_wdata[1]; msingle = cpu_wdata[2];
              if (cpu_wdata[0]) begin
                if (mc == 0) mdone = 1; else mrun = 1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle comparison and event counters
  int done_cnt = 0, rise_cnt = 0;
  logic prev_req = 1'b0;
  int pq[$];
  bit e_req, e_x;
  int e_addr, e_rdata;
  always @(negedge clk) begin
    if (rst_n) begin
      e_req = mrun && !mgap;
      e_x = e_req && bus_gnt;
      e_addr = bus_gnt ? ma : 0;
      e_rdata = 0;
      if (!bus_gnt && cpu_sel && cpu_rd)
        case (reg_sel)
          2'd0: e_rdata = ma;
          2'd1: e_rdata = mc;
          2'd2: e_rdata = {msingle, mdir, mrun};
          default: e_rdata = 0;
        endcase
      chk(bus_req === e_req, "R7 bus_req vs model", bus_req, e_req);
      chk(mem_rd === (e_x && !mdir), "R6 mem_rd vs model", mem_rd, e_x && !mdir);
      chk(mem_wr === (e_x && mdir), "R6 mem_wr vs model", mem_wr, e_x && mdir);
      chk(per_take === (e_x && mdir), "R6 per_take vs model", per_take, e_x && mdir);
      chk(!(mem_rd && mem_wr), "R12 both strobes", {mem_rd, mem_wr}, 0);
      chk(mem_addr === e_addr[15:0], "R5 mem_addr vs model", mem_addr, e_addr);
      if (e_x && mdir)
        chk(mem_wdata === {8'hC5, ma[7:0]}, "R6 mem_wdata", mem_wdata, {8'hC5, ma[7:0]});
      chk(done_irq === mdone, "R9 done_irq vs model", done_irq, mdone);
      chk(per_valid === mpv, "R6 per_valid vs model", per_valid, mpv);
      if (mpv) chk(per_dout === mpd[15:0], "R6 per_dout vs model", per_dout, mpd);
      chk(cpu_rdata === e_rdata[15:0], "R2 cpu_rdata vs model", cpu_rdata, e_rdata);
      if (done_irq) done_cnt++;
      if (bus_req && !prev_req) rise_cnt++;
      if (per_valid) pq.push_back(per_dout);
      prev_req = bus_req;
    end
    req_s = bus_req;
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask
  task automatic wr(input logic [1:0] r, input logic [15:0] d);
    cpu_sel = 1; reg_sel = r; cpu_wr = 1; cpu_wdata = d;
    cyc();
    cpu_sel = 0; cpu_wr = 0;
  endtask
  task automatic rd(input logic [1:0] r, input logic [15:0] exp, input string tag);
    cpu_sel = 1; reg_sel = r; cpu_rd = 1;
    @(negedge clk);
    chk(cpu_rdata === exp, tag, cpu_rdata, exp);
    cyc();
    cpu_sel = 0; cpu_rd = 0;
  endtask

  int d0, r0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        // R1 reset state
        @(negedge clk);
        chk(bus_req === 1'b0 && done_irq === 1'b0 && per_valid === 1'b0, "R1 outputs after reset",
            {bus_req, done_irq, per_valid}, 0);
        cyc();
        rd(2'd0, 16'h0, "R1 address reset");
        rd(2'd1, 16'h0, "R1 count reset");
        rd(2'd2, 16'h0, "R1 control reset");
        arb_en = 1;
        // R2 register access
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'h0004);
        wr(2'd2, 16'h0006);
        rd(2'd0, 16'h0010, "R2 address readback");
        rd(2'd1, 16'h0004, "R2 count readback");
        rd(2'd2, 16'h0006, "R2 control readback");
        rd(2'd3, 16'h0000, "R2 index 3 reads zero");
        // R3 access gating under grant
        arb_en = 0; bus_gnt = 1;
        wr(2'd0, 16'h0077);
        rd(2'd0, 16'h0000, "R3 read under grant is zero");
        bus_gnt = 0;
        rd(2'd0, 16'h0010, "R3 write under grant ignored");
        arb_en = 1;
        // R10 zero-count start
        wr(2'd1, 16'h0000);
        r0 = rise_cnt;
        wr(2'd2, 16'h0001);
        @(negedge clk);
        chk(done_irq === 1'b1, "R10 immediate done", done_irq, 1);
        cyc();
        repeat (6) cyc();
        chk(rise_cnt == r0, "R10 no request", rise_cnt, r0);
        // burst read R4 R5 R6 R7 R9
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'h0004);
        d0 = done_cnt; r0 = rise_cnt; pq.delete();
        wr(2'd2, 16'h0001);
        @(negedge clk);
        chk(bus_req === 1'b1, "R4 request after start", bus_req, 1);
        cyc();
        repeat (20) cyc();
        chk(done_cnt == d0 + 1, "R9 one done pulse", done_cnt, d0 + 1);
        chk(rise_cnt == r0 + 1, "R7 burst holds request", rise_cnt, r0 + 1);
        chk(pq.size() == 4, "R6 four words out", pq.size(), 4);
        for (int i = 0; i < 4 && i < pq.size(); i++)
          chk(pq[i] == 32'h1010 + i, "R6 peripheral word", pq[i], 32'h1010 + i);
        rd(2'd0, 16'h0014, "R5 address advanced");
        rd(2'd1, 16'h0000, "R9 count zero");
        rd(2'd2, 16'h0000, "R9 run bit cleared");
        // single-word write R8
        wr(2'd0, 16'h0040);
        wr(2'd1, 16'h0003);
        d0 = done_cnt; r0 = rise_cnt;
        wr(2'd2, 16'h0007);
        repeat (30) cyc();
        chk(rise_cnt == r0 + 3, "R8 one request per word", rise_cnt, r0 + 3);
        chk(done_cnt == d0 + 1, "R9 done after single mode", done_cnt, d0 + 1);
        for (int i = 0; i < 3; i++)
          chk(mem[64 + i] == 16'hC540 + 16'(i), "R6 memory written", mem[64 + i], 16'hC540 + 16'(i));
        chk(mem[67] == 16'h1043, "R6 memory past block untouched", mem[67], 16'h1043);
        // abort R11
        arb_en = 0; bus_gnt = 0;
        wr(2'd0, 16'h0080);
        wr(2'd1, 16'h0005);
        d0 = done_cnt;
        wr(2'd2, 16'h0001);
        @(negedge clk);
        chk(bus_req === 1'b1, "R4 request while grant held off", bus_req, 1);
        cyc();
        wr(2'd0, 16'h0099);
        wr(2'd1, 16'h0009);
        rd(2'd0, 16'h0080, "R11 address write ignored");
        rd(2'd1, 16'h0005, "R11 count write ignored");
        wr(2'd2, 16'h0000);
        @(negedge clk);
        chk(bus_req === 1'b0, "R11 abort drops request", bus_req, 0);
        cyc();
        repeat (5) cyc();
        chk(done_cnt == d0, "R11 no done on abort", done_cnt, d0);
        rd(2'd2, 16'h0000, "R11 run cleared");
        rd(2'd1, 16'h0005, "R11 count kept");
      end
      begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule